// File: doc/BRIEF.md
# SPI-Attached UART Host Controller

This block is the host end of a link to an external UART device that is programmed and read through a 16-bit SPI command port. Local logic sees two simple byte streams. On the transmit side a byte is offered with a valid/ready handshake. On the receive side a data-available flag, a head byte and a pop strobe are provided. The controller turns these into SPI frames. The two top bits of each frame select one of four operations: data read (00), configuration read (01), data write (10) and configuration write (11). In every response, bit 15 reports that the device holds a received character and bit 14 reports that its transmit buffer is empty.

After reset the controller derives a 4-bit baud code from the requested line rate. It writes that code in a configuration frame, reads it back and compares the low 14 bits of the response. On a mismatch it waits a programmable gap and tries again. After a bounded number of attempts it gives up and flags the failure. From then on it serves the byte streams. Before each write it polls until the device reports its transmit buffer empty. It keeps any character that comes back with a write frame. On request it drains pending characters into a local ring buffer. A line feed can optionally be expanded into a carriage return followed by a line feed.

Top module: `spi_uart_host`

## Requirements
- R1: Between frames the chip select and the serial clock both sit high. A frame pulls the clock low together with chip select, then makes 16 rising edges. MOSI carries the command MSB first and holds steady while the clock is high. MISO is sampled at the end of each high phase. The frame ends with the clock high and chip select raised.
- R2: A data-write frame (bits 15:14 = 10, byte in bits 7:0) is only sent after a configuration-read frame (01) whose response had bit 14 set. `tx_ready` is high only while the controller is idle and the bus is quiet.
- R3: When a data-write response has bit 15 set and the local buffer is not full, response bits 7:0 are appended to the receive buffer. When the buffer is full, that character is dropped.
- R4: The receive buffer holds BUF_DEPTH (16) bytes, delivered in arrival order across index wrap-around. Its fill count never exceeds the depth, and a full buffer is never overwritten.
- R5: A pulse on `rx_poll` while idle with an empty buffer starts exactly one drain sequence. Data-read frames (00) repeat while response bit 15 is set, each storing bits 7:0. The sequence stops when bit 15 is clear or the buffer becomes full. A poll with nothing pending costs one frame.
- R6: Initialisation sends a configuration write (11, baud code in bits 3:0, bits 13:4 zero), then a configuration read (01). It completes with `init_done` high when response bits 13:0 equal the written word.
- R7: After a mismatched read-back, at least RETRY_GAP clock cycles pass before the next configuration write. After RETRY_MAX writes without a match, `init_fail` goes high and normal service still starts. `init_done` and `init_fail` are never both high.
- R8: The baud code is 0 for 230400, 1 for 115200, 2 for 57600, 9 for 38400, 10 for 19200, 11 for 9600, 12 for 4800, 13 for 2400, 14 for 1200 and 15 for 600. Any other rate selects code 1.
- R9: With CRLF_EN set, a transmit byte 0x0A goes out on the line as 0x0D followed by 0x0A. Every other byte goes out unchanged and in order.
- R10: `rx_avail` is high exactly when the buffer holds a byte, and `rx_data` shows the oldest one. A pop with `rx_avail` low is ignored and starts no frame.
- R11: `tx_ready` stays low until initialisation has either succeeded or given up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_baud | input | 18 | Requested line rate in bit/s, held stable during initialisation |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Controller idle, byte accepted when valid |
| rx_data | output | 8 | Oldest buffered received byte |
| rx_avail | output | 1 | Receive buffer not empty |
| rx_pop | input | 1 | Remove the oldest buffered byte |
| rx_poll | input | 1 | Query the device once for pending characters |
| init_done | output | 1 | Configuration verified |
| init_fail | output | 1 | Configuration attempts exhausted |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Command bits to the device |
| spi_miso | input | 1 | Response bits from the device |

## Verification
The hardest state to reach is a full local buffer at the moment a write response carries a piggybacked character. The drop in that case can only be seen by noticing a byte that never comes out. The bench builds it deliberately: it queues exactly sixteen characters in its device model, polls once to fill the buffer, then queues one more character and sends a byte. Draining the buffer afterwards must give only the original sixteen. The retry path is exercised by a device model that refuses a chosen number of configuration writes. It also times the gap between each read-back and the next write.

// File: rtl/spi_uart_pkg.sv
package spi_uart_pkg;

   localparam logic [1:0] OP_RD_DATA = 2'b00;
   localparam logic [1:0] OP_RD_CFG  = 2'b01;
   localparam logic [1:0] OP_WR_DATA = 2'b10;
   localparam logic [1:0] OP_WR_CFG  = 2'b11;

   localparam int RX_FLAG_BIT = 15;
   localparam int TX_FLAG_BIT = 14;

   typedef enum logic [2:0] {
      S_INIT_WR,
      S_INIT_RD,
      S_INIT_GAP,
      S_IDLE,
      S_TX_POLL,
      S_TX_WRITE,
      S_DRAIN
   } ctl_state_e;

   function automatic logic [3:0] rate_to_code(input logic [17:0] rate);
      case (rate)
         18'd230400: return 4'd0;
         18'd115200: return 4'd1;
         18'd57600:  return 4'd2;
         18'd38400:  return 4'd9;
         18'd19200:  return 4'd10;
         18'd9600:   return 4'd11;
         18'd4800:   return 4'd12;
         18'd2400:   return 4'd13;
         18'd1200:   return 4'd14;
         18'd600:    return 4'd15;
         default:    return 4'd1;
      endcase
   endfunction

endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
   parameter int FRAME_W  = 16,
   parameter int HALF_CYC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               busy,
   output logic               done,
   output logic [FRAME_W-1:0] rx_word,
   output logic               sclk,
   output logic               cs_n,
   output logic               mosi,
   input  logic               miso
);
   localparam int CW = $clog2(HALF_CYC + 1);
   localparam int BW = $clog2(FRAME_W + 1);

   if (HALF_CYC < 1) begin : g_bad_half
      $error("spi_frame_engine: HALF_CYC must be at least 1");
   end
   if (FRAME_W < 2) begin : g_bad_width
      $error("spi_frame_engine: FRAME_W must be at least 2");
   end

   logic               active;
   logic [CW-1:0]      tmr;
   logic [BW-1:0]      bitcnt;
   logic [FRAME_W-1:0] sh_out;
   logic [FRAME_W-1:0] sh_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk   <= 1'b1;
         cs_n   <= 1'b1;
         done   <= 1'b0;
         tmr    <= '0;
         bitcnt <= '0;
         sh_out <= '0;
         sh_in  <= '0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               sclk   <= 1'b0;
               cs_n   <= 1'b0;
               sh_out <= tx_word;
               tmr    <= CW'(HALF_CYC - 1);
               bitcnt <= '0;
            end
         end else if (tmr != '0) begin
            tmr <= tmr - 1'b1;
         end else if (!sclk) begin
            sclk <= 1'b1;
            tmr  <= CW'(HALF_CYC - 1);
         end else begin
            sh_in <= {sh_in[FRAME_W-2:0], miso};
            if (bitcnt == BW'(FRAME_W - 1)) begin
               active <= 1'b0;
               cs_n   <= 1'b1;
               done   <= 1'b1;
            end else begin
               sclk   <= 1'b0;
               sh_out <= {sh_out[FRAME_W-2:0], 1'b0};
               bitcnt <= bitcnt + 1'b1;
               tmr    <= CW'(HALF_CYC - 1);
            end
         end
      end
   end

   assign busy    = active;
   assign mosi    = sh_out[FRAME_W-1];
   assign rx_word = sh_in;

endmodule

// File: rtl/rx_ring.sv
module rx_ring #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               push_data,
   input  logic                       pop,
   output logic [W-1:0]               head,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_ring: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_idx, rd_idx;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && !full;
   assign head    = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wr_idx] <= push_data;
            wr_idx      <= wr_idx + 1'b1;
         end
         if (do_pop) rd_idx <= rd_idx + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/spi_uart_host.sv
module spi_uart_host
   import spi_uart_pkg::*;
#(
   parameter int HALF_CYC  = 4,
   parameter int BUF_DEPTH = 16,
   parameter int RETRY_GAP = 1000,
   parameter int RETRY_MAX = 100,
   parameter bit CRLF_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [17:0] cfg_baud,
   input  logic [7:0]  tx_data,
   input  logic        tx_valid,
   output logic        tx_ready,
   output logic [7:0]  rx_data,
   output logic        rx_avail,
   input  logic        rx_pop,
   input  logic        rx_poll,
   output logic        init_done,
   output logic        init_fail,
   output logic        spi_sclk,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int FW    = 16;
   localparam int CNT_W = $clog2(BUF_DEPTH + 1);
   localparam int GAP_W = $clog2(RETRY_GAP + 1);
   localparam int TRY_W = $clog2(RETRY_MAX + 1);

   if (RETRY_MAX < 1 || RETRY_GAP < 1) begin : g_bad_retry
      $error("spi_uart_host: RETRY_MAX and RETRY_GAP must be at least 1");
   end

   ctl_state_e       st;
   logic             inflight;
   logic             eng_start, eng_busy, eng_done;
   logic [FW-1:0]    eng_tx, eng_rx;
   logic [7:0]       cur_byte;
   logic             lf_pend;
   logic [3:0]       cfg_code;
   logic [GAP_W-1:0] gap_tmr;
   logic [TRY_W-1:0] tries;
   logic             ring_push, ring_full, ring_empty;
   logic [CNT_W-1:0] rx_count;
   logic [7:0]       first_byte;
   logic             first_lf;
   logic             frame_state;

   // Line-feed expansion variant.
   if (CRLF_EN) begin : g_crlf
      assign first_lf   = (tx_data == 8'h0A);
      assign first_byte = first_lf ? 8'h0D : tx_data;
   end else begin : g_raw
      assign first_lf   = 1'b0;
      assign first_byte = tx_data;
   end

   assign frame_state = (st == S_INIT_WR) || (st == S_INIT_RD) || (st == S_TX_POLL)
                     || (st == S_TX_WRITE) || (st == S_DRAIN);
   assign eng_start   = frame_state && !inflight;

   always_comb begin
      case (st)
         S_INIT_WR:  eng_tx = {OP_WR_CFG, 10'd0, rate_to_code(cfg_baud)};
         S_INIT_RD:  eng_tx = {OP_RD_CFG, 14'd0};
         S_TX_POLL:  eng_tx = {OP_RD_CFG, 14'd0};
         S_TX_WRITE: eng_tx = {OP_WR_DATA, 6'd0, cur_byte};
         default:    eng_tx = {OP_RD_DATA, 14'd0};
      endcase
   end

   assign ring_push = eng_done && eng_rx[RX_FLAG_BIT] && !ring_full
                   && ((st == S_TX_WRITE) || (st == S_DRAIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_INIT_WR;
         inflight  <= 1'b0;
         cur_byte  <= '0;
         lf_pend   <= 1'b0;
         cfg_code  <= '0;
         gap_tmr   <= '0;
         tries     <= '0;
         init_done <= 1'b0;
         init_fail <= 1'b0;
      end else begin
         if (eng_start) inflight <= 1'b1;
         if (eng_done)  inflight <= 1'b0;
         if (eng_start && st == S_INIT_WR) cfg_code <= rate_to_code(cfg_baud);
         case (st)
            S_INIT_WR: if (eng_done) st <= S_INIT_RD;
            S_INIT_RD: if (eng_done) begin
               if (eng_rx[13:0] == {10'd0, cfg_code}) begin
                  init_done <= 1'b1;
                  st        <= S_IDLE;
               end else if (tries == TRY_W'(RETRY_MAX - 1)) begin
                  init_fail <= 1'b1;
                  st        <= S_IDLE;
               end else begin
                  tries   <= tries + 1'b1;
                  gap_tmr <= GAP_W'(RETRY_GAP - 1);
                  st      <= S_INIT_GAP;
               end
            end
            S_INIT_GAP: begin
               if (gap_tmr == '0) st <= S_INIT_WR;
               else gap_tmr <= gap_tmr - 1'b1;
            end
            S_IDLE: begin
               if (tx_valid) begin
                  cur_byte <= first_byte;
                  lf_pend  <= first_lf;
                  st       <= S_TX_POLL;
               end else if (rx_poll && ring_empty) begin
                  st <= S_DRAIN;
               end
            end
            S_TX_POLL: if (eng_done && eng_rx[TX_FLAG_BIT]) st <= S_TX_WRITE;
            S_TX_WRITE: if (eng_done) begin
               if (lf_pend) begin
                  cur_byte <= 8'h0A;
                  lf_pend  <= 1'b0;
                  st       <= S_TX_POLL;
               end else begin
                  st <= S_IDLE;
               end
            end
            S_DRAIN: if (eng_done) begin
               if (!(eng_rx[RX_FLAG_BIT] && rx_count < CNT_W'(BUF_DEPTH - 1))) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign tx_ready = (st == S_IDLE);
   assign rx_avail = !ring_empty;

   spi_frame_engine #(.FRAME_W(FW), .HALF_CYC(HALF_CYC)) eng_i (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_word(eng_tx),
      .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
      .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
   );

   rx_ring #(.DEPTH(BUF_DEPTH), .W(8)) ring_i (
      .clk(clk), .rst_n(rst_n), .push(ring_push), .push_data(eng_rx[7:0]),
      .pop(rx_pop), .head(rx_data), .count(rx_count), .full(ring_full),
      .empty(ring_empty)
   );

endmodule

// File: rtl/spi_uart_host_chk.sv
module spi_uart_host_chk #(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       spi_cs_n,
   input logic                       spi_sclk,
   input logic                       spi_mosi,
   input logic                       tx_ready,
   input logic                       init_done,
   input logic                       init_fail,
   input logic                       rx_avail,
   input logic                       rx_pop,
   input logic                       ring_push,
   input logic [$clog2(DEPTH+1)-1:0] rx_count
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   p_clk_high_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> spi_sclk);

   p_mosi_steady_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && spi_sclk && $past(spi_sclk) && !$past(spi_cs_n)) |-> $stable(spi_mosi));

   p_ready_bus_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> spi_cs_n);

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(DEPTH));

   p_init_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_done && init_fail));

   p_last_pop_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CNT_W'(1) && rx_pop && !ring_push) |=> !rx_avail);

   p_ready_after_init_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (init_done || init_fail));

endmodule

bind spi_uart_host spi_uart_host_chk #(.DEPTH(BUF_DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
   .spi_mosi(spi_mosi), .tx_ready(tx_ready), .init_done(init_done),
   .init_fail(init_fail), .rx_avail(rx_avail), .rx_pop(rx_pop),
   .ring_push(ring_push), .rx_count(rx_count)
);

// File: tb/spi_uart_host_tb_top.sv
module spi_uart_host_tb_top;
   localparam int TCLK  = 10;
   localparam int HALF  = 2;
   localparam int DEPTH = 16;
   localparam int GAP   = 40;
   localparam int RMAX  = 4;
   localparam int WDOG  = 150000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [17:0] cfg_baud;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_ready;
   logic [7:0]  rx_data;
   logic        rx_avail, rx_pop, rx_poll;
   logic        init_done, init_fail;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso;

   always #(TCLK/2) clk = ~clk;

   spi_uart_host #(.HALF_CYC(HALF), .BUF_DEPTH(DEPTH), .RETRY_GAP(GAP),
                   .RETRY_MAX(RMAX), .CRLF_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_baud(cfg_baud), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
      .rx_avail(rx_avail), .rx_pop(rx_pop), .rx_poll(rx_poll),
      .init_done(init_done), .init_fail(init_fail), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Expected baud code per requirement R8.
   function automatic int exp_code(input int rate);
      case (rate)
         230400: return 0;  115200: return 1;  57600: return 2;
         38400:  return 9;  19200:  return 10; 9600:  return 11;
         4800:   return 12; 2400:   return 13; 1200:  return 14;
         600:    return 15;
         default: return 1;
      endcase
   endfunction

   // ---------------- device model ----------------
   logic [15:0] m_cmd, m_resp;
   logic [13:0] m_cfg = '0;
   logic [13:0] last_wc = '0;
   logic        m_t = 1'b1;
   int          nrise = 0;
   int          busy_left = 0;
   int          reject_left = 0;
   int          wc_count = 0, rd_count = 0, frames = 0, t_violation = 0;
   time         t_start = 0, prev_end = 0;
   int          min_gap = 1000000;
   logic [7:0]  dev_q[$];
   logic [7:0]  exp_buf[$];
   logic [7:0]  tx_log[$];
   logic [7:0]  exp_tx[$];
   logic        miso_q = 1'b1;

   assign spi_miso = miso_q;

   always @(negedge spi_cs_n) begin
      nrise   = 0;
      m_cmd   = '0;
      t_start = $time;
      m_resp  = {(dev_q.size() != 0), m_t, 14'd0};
      miso_q  = m_resp[15];
   end

   always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
      m_cmd = {m_cmd[14:0], spi_mosi};
      nrise++;
      if (nrise == 2) begin
         if (m_cmd[1:0] == 2'b01) m_resp[13:0] = m_cfg;
         else if (m_cmd[1:0] != 2'b11 && m_resp[15]) m_resp[13:0] = {6'd0, dev_q[0]};
      end
   end

   always @(negedge spi_sclk) if (spi_cs_n === 1'b0 && nrise < 16) miso_q = m_resp[15 - nrise];

   always @(posedge spi_cs_n) if (nrise == 16) begin
      frames++;
      case (m_cmd[15:14])
         2'b11: begin
            wc_count++;
            if (wc_count > 1) begin
               if (int'((t_start - prev_end) / TCLK) < min_gap) min_gap = int'((t_start - prev_end) / TCLK);
            end
            last_wc = m_cmd[13:0];
            if (reject_left > 0) reject_left--;
            else m_cfg = m_cmd[13:0];
         end
         2'b01: begin
            if (!m_t) begin
               if (busy_left > 0) busy_left--;
               if (busy_left == 0) m_t = 1'b1;
            end
         end
         2'b10: begin
            if (!m_t) t_violation++;
            tx_log.push_back(m_cmd[7:0]);
            busy_left = $urandom_range(0, 3);
            m_t = (busy_left == 0);
         end
         default: rd_count++;
      endcase
      if (m_cmd[15:14] inside {2'b00, 2'b10} && m_resp[15]) begin
         logic [7:0] b;
         b = dev_q.pop_front();
         if (exp_buf.size() < DEPTH) exp_buf.push_back(b);
      end
      prev_end = $time;
      nrise = 0;
   end

   // ---------------- stimulus tasks ----------------
   task automatic wait_ready();
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] b);
      if (b == 8'h0A) exp_tx.push_back(8'h0D);
      exp_tx.push_back(b);
      wait_ready();
      tx_data = b; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic poll_once();
      wait_ready();
      rx_poll = 1'b1;
      @(negedge clk);
      rx_poll = 1'b0;
      wait_ready();
   endtask

   task automatic pop_check(input string req);
      logic [7:0] e;
      @(negedge clk);
      chk(rx_avail == 1'b1, req, "rx_avail before pop", int'(rx_avail), 1);
      if (rx_avail && exp_buf.size() > 0) begin
         e = exp_buf.pop_front();
         chk(rx_data == e, req, "rx_data order", int'(rx_data), int'(e));
      end
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic drain_all(input string req);
      forever begin
         poll_once();
         if (!rx_avail) break;
         while (rx_avail) pop_check(req);
      end
      chk(exp_buf.size() == 0, req, "expected bytes left undelivered", exp_buf.size(), 0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      chk(1'b0, "WDOG", "run did not finish", WDOG, 0);
      summary();
   end

   initial begin : main
      int f0, r0;
      void'($urandom(32'd2024));
      rst_n = 1'b0; tx_valid = 1'b0; rx_pop = 1'b0; rx_poll = 1'b0;
      tx_data = '0; cfg_baud = 18'd9600; reject_left = 2;
      repeat (4) @(negedge clk);
      // R1, R11: reset state
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b1, "R1", "idle bus in reset", {spi_cs_n, spi_sclk}, 3);
      chk(tx_ready == 1'b0 && rx_avail == 1'b0, "R11", "ready/avail in reset", {tx_ready, rx_avail}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_ready == 1'b0, "R11", "ready before init", int'(tx_ready), 0);
      wait_ready();
      // R6, R7, R8: configuration with two refused writes
      chk(init_done == 1'b1 && init_fail == 1'b0, "R6", "init flags", {init_done, init_fail}, 2);
      chk(wc_count == 3, "R7", "config writes with two refusals", wc_count, 3);
      chk(min_gap >= GAP, "R7", "retry gap cycles", min_gap, GAP);
      chk(int'(m_cfg) == exp_code(9600), "R8", "programmed code 9600", int'(m_cfg), exp_code(9600));

      // R9, R2: directed line-feed expansion
      send_char(8'h41); send_char(8'h0A); send_char(8'h42);
      // R2: random bytes with random transmit-busy periods
      for (int i = 0; i < 24; i++) send_char((i % 7 == 3) ? 8'h0A : 8'($urandom_range(0, 255)));
      wait_ready();
      chk(tx_log.size() == exp_tx.size(), "R9", "line byte count", tx_log.size(), exp_tx.size());
      for (int i = 0; i < exp_tx.size() && i < tx_log.size(); i++)
         chk(tx_log[i] == exp_tx[i], "R9", "line byte", int'(tx_log[i]), int'(exp_tx[i]));
      chk(t_violation == 0, "R2", "writes while transmitter busy", t_violation, 0);

      // R5: poll with nothing pending
      r0 = rd_count;
      poll_once();
      chk(rd_count == r0 + 1, "R5", "frames for empty poll", rd_count - r0, 1);
      chk(rx_avail == 1'b0, "R5", "avail after empty poll", int'(rx_avail), 0);

      // R10: pop while empty is ignored
      f0 = frames;
      rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
      repeat (3) @(negedge clk);
      chk(rx_avail == 1'b0 && frames == f0, "R10", "pop on empty", frames - f0, 0);

      // R4, R5: 20 pending bytes, one poll fills exactly 16
      for (int i = 0; i < 20; i++) dev_q.push_back(8'($urandom_range(0, 255)));
      poll_once();
      chk(dev_q.size() == 4, "R5", "device bytes left after full drain", dev_q.size(), 4);
      for (int i = 0; i < DEPTH; i++) pop_check("R4");
      @(negedge clk);
      chk(rx_avail == 1'b0, "R10", "avail after last pop", int'(rx_avail), 0);
      drain_all("R5");

      // R3: byte returned with a write frame
      dev_q.push_back(8'hC3); dev_q.push_back(8'h5A);
      send_char(8'h31);
      wait_ready();
      chk(rx_avail == 1'b1 && rx_data == 8'hC3, "R3", "piggyback capture", int'(rx_data), 8'hC3);
      chk(dev_q.size() == 1, "R3", "device queue after write", dev_q.size(), 1);
      drain_all("R3");

      // R3, R4: piggyback while full is dropped, buffer not overwritten
      for (int i = 0; i < DEPTH; i++) dev_q.push_back(8'(8'h80 + i));
      poll_once();
      dev_q.push_back(8'hEE);
      send_char(8'h32);
      wait_ready();
      chk(exp_buf.size() == DEPTH, "R3", "reference holds full buffer", exp_buf.size(), DEPTH);
      for (int i = 0; i < DEPTH; i++) pop_check("R4");
      @(negedge clk);
      chk(rx_avail == 1'b0, "R3", "dropped byte absent", int'(rx_avail), 0);

      // mixed random traffic
      for (int it = 0; it < 40; it++) begin
         int k;
         k = $urandom_range(0, 3);
         for (int j = 0; j < k; j++) dev_q.push_back(8'($urandom_range(0, 255)));
         if ($urandom_range(0, 1) == 1) send_char(8'($urandom_range(0, 255)));
         if ($urandom_range(0, 2) == 0) poll_once();
         wait_ready();
         while (rx_avail && $urandom_range(0, 3) != 0) pop_check("R4");
      end
      drain_all("R5");
      wait_ready();
      chk(tx_log.size() == exp_tx.size(), "R9", "total line bytes", tx_log.size(), exp_tx.size());
      for (int i = 0; i < exp_tx.size() && i < tx_log.size(); i++)
         if (tx_log[i] != exp_tx[i]) chk(1'b0, "R2", "line byte", int'(tx_log[i]), int'(exp_tx[i]));
      chk(t_violation == 0, "R2", "writes while busy, mixed", t_violation, 0);

      // R7, R8: device refuses every write, unsupported rate
      rst_n = 1'b0;
      cfg_baud = 18'd31250; reject_left = 1000; wc_count = 0; min_gap = 1000000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_ready();
      chk(init_fail == 1'b1 && init_done == 1'b0, "R7", "give-up flags", {init_done, init_fail}, 1);
      chk(wc_count == RMAX, "R7", "attempt count", wc_count, RMAX);
      chk(min_gap >= GAP, "R7", "retry gap after refusal", min_gap, GAP);
      chk(int'(last_wc) == exp_code(31250), "R8", "fallback code", int'(last_wc), exp_code(31250));
      summary();
   end

endmodule